// File: doc/BRIEF.md
# UART Interrupt and Status Controller

This block holds the status and interrupt registers of a FIFO-based UART. It watches the occupancy counts of the receive and transmit FIFOs and a set of one-cycle event pulses from the receiver and transmitter. From them it derives a live status word, a sticky raw interrupt register and an interrupt mask, and it drives one level-sensitive interrupt line.

Software reaches the block through a simple register bus with a byte address, a write strobe with write data, and a read data output that is combinational on the address. The mask is changed only through a write-one-to-set port and a write-one-to-clear port. The raw interrupt register is cleared by writing ones. The FIFOs, the shifters and the baud logic live outside this block.

Top module: `uart_irq_ctrl`

## Requirements
- R1: Live status (read at 0x2C) bit 0 is high when the RX count is at or above the RX trigger level, bit 1 when the RX count is zero, and bit 2 when the RX count equals the FIFO depth (64 by default).
- R2: Live status bit 3 is high when the TX count is zero, bit 4 when it equals the FIFO depth, and bit 13 when it is at or above the TX trigger level; this last condition sets raw bit 10, not raw bit 13.
- R3: In any cycle where live status bits 4:0 are high, the matching raw bits (read at 0x14) are set on the next clock edge and stay set until cleared.
- R4: A one-cycle event pulse sets its raw bit on the next edge: RX overrun bit 5, framing error bit 6, parity error bit 7, receive timeout bit 8, modem status change bit 9, TX overflow bit 12.
- R5: A write to 0x08 ORs the written bits into the mask (read at 0x10); the mask keeps only implemented bits 10:0 and 12 (mask 0x17FF).
- R6: A write to 0x0C clears the written bits in the mask; a write to 0x10 leaves the mask unchanged.
- R7: The interrupt output is high exactly when some bit is set in both the mask and the raw register.
- R8: A write to 0x14 clears the raw bits written as one and leaves the others.
- R9: When a clear write and a set condition hit the same raw bit in the same cycle, the bit ends up set.
- R10: Reads of unmapped offsets (for example 0x00, 0x04, 0x30) return zero; writes to unmapped offsets and to 0x2C change no register.
- R11: After reset the mask and raw registers are zero and the RX trigger (0x20) and TX trigger (0x44) levels are 0x20; trigger writes keep the low 7 bits and read back zero-extended.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rx_count_i | input | CNT_W | RX FIFO occupancy |
| tx_count_i | input | CNT_W | TX FIFO occupancy |
| ev_rx_ovr_i | input | 1 | RX overrun pulse |
| ev_frame_i | input | 1 | Framing error pulse |
| ev_parity_i | input | 1 | Parity error pulse |
| ev_rx_tmo_i | input | 1 | Receive timeout pulse |
| ev_modem_i | input | 1 | Modem status change pulse |
| ev_tx_ovf_i | input | 1 | TX overflow pulse |
| addr_i | input | 8 | Register byte address |
| wr_en_i | input | 1 | Write strobe |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for addr_i |
| irq_o | output | 1 | Level interrupt |

## Verification
On every cycle the assertions check that raw bits never drop without a clear, never rise without a set condition, that a set condition always leaves its bit high, that the mask moves only on an enable or disable strobe, and that the empty and full status flags never coincide. The numeric relations between counts and trigger levels, the bit positions of each event and of the misplaced TX trigger bit, the mask readback, and the decoding of unmapped offsets are shown only by the bench's sweeps and directed scenarios.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;
  localparam int ADDR_W = 8;
  localparam int DW     = 32;

  localparam logic [ADDR_W-1:0] OFS_IEN   = 8'h08;
  localparam logic [ADDR_W-1:0] OFS_IDIS  = 8'h0C;
  localparam logic [ADDR_W-1:0] OFS_MASK  = 8'h10;
  localparam logic [ADDR_W-1:0] OFS_RAW   = 8'h14;
  localparam logic [ADDR_W-1:0] OFS_RXTRG = 8'h20;
  localparam logic [ADDR_W-1:0] OFS_STAT  = 8'h2C;
  localparam logic [ADDR_W-1:0] OFS_TXTRG = 8'h44;

  localparam int B_RX_TRG  = 0;
  localparam int B_RX_EMP  = 1;
  localparam int B_RX_FUL  = 2;
  localparam int B_TX_EMP  = 3;
  localparam int B_TX_FUL  = 4;
  localparam int B_RX_OVR  = 5;
  localparam int B_FRAME   = 6;
  localparam int B_PARITY  = 7;
  localparam int B_RX_TMO  = 8;
  localparam int B_MODEM   = 9;
  localparam int B_TX_TRG_RAW  = 10;
  localparam int B_TX_OVF  = 12;
  localparam int B_TX_TRG_STAT = 13;

  localparam logic [DW-1:0] IRQ_IMPL = 32'h0000_17FF;
endpackage

// File: rtl/uart_irq_status.sv
module uart_irq_status
  import uart_irq_pkg::*;
#(
  parameter int DEPTH = 64,
  parameter int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CNT_W-1:0] rx_count_i,
  input  logic [CNT_W-1:0] tx_count_i,
  input  logic [CNT_W-1:0] rx_trig_i,
  input  logic [CNT_W-1:0] tx_trig_i,
  output logic [DW-1:0]    status_o
);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(DEPTH);

  always_comb begin
    status_o                = '0;
    status_o[B_RX_TRG]      = (rx_count_i >= rx_trig_i);
    status_o[B_RX_EMP]      = (rx_count_i == '0);
    status_o[B_RX_FUL]      = (rx_count_i == FULL);
    status_o[B_TX_EMP]      = (tx_count_i == '0);
    status_o[B_TX_FUL]      = (tx_count_i == FULL);
    status_o[B_TX_TRG_STAT] = (tx_count_i >= tx_trig_i);
  end

  AST_RX_EMPTY_FULL_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(status_o[B_RX_EMP] && status_o[B_RX_FUL])); // R1
  AST_TX_EMPTY_FULL_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(status_o[B_TX_EMP] && status_o[B_TX_FUL])); // R2
endmodule

// File: rtl/uart_irq_raw.sv
module uart_irq_raw
  import uart_irq_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [DW-1:0] set_i,
  input  logic [DW-1:0] clr_i,
  output logic [DW-1:0] raw_o
);
  logic [DW-1:0] raw_q;

  // set beats clear on the same bit
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) raw_q <= '0;
    else         raw_q <= ((raw_q & ~clr_i) | set_i) & IRQ_IMPL;
  end

  assign raw_o = raw_q;

  AST_RAW_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((raw_q & $past(raw_q & ~clr_i)) == $past(raw_q & ~clr_i))); // R3
  AST_RAW_SET_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((raw_q & $past(set_i & IRQ_IMPL)) == $past(set_i & IRQ_IMPL))); // R9
  AST_RAW_NO_SPURIOUS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((raw_q & ~$past(raw_q) & ~$past(set_i)) == '0)); // R4
endmodule

// File: rtl/uart_irq_mask.sv
module uart_irq_mask
  import uart_irq_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic          dis_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] mask_o
);
  logic [DW-1:0] mask_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    mask_q <= '0;
    else if (en_i)  mask_q <= (mask_q | wdata_i) & IRQ_IMPL;
    else if (dis_i) mask_q <= mask_q & ~wdata_i;
  end

  assign mask_o = mask_q;

  AST_MASK_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i && !dis_i |=> $stable(mask_q)); // R6
  AST_MASK_IMPL_ONLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i |=> ((mask_q & ~IRQ_IMPL) == '0)); // R5
endmodule

// File: rtl/uart_irq_ctrl.sv
module uart_irq_ctrl
  import uart_irq_pkg::*;
#(
  parameter int DEPTH    = 64,
  parameter int TRIG_RST = 32,
  localparam int CNT_W   = $clog2(DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [CNT_W-1:0]  rx_count_i,
  input  logic [CNT_W-1:0]  tx_count_i,
  input  logic              ev_rx_ovr_i,
  input  logic              ev_frame_i,
  input  logic              ev_parity_i,
  input  logic              ev_rx_tmo_i,
  input  logic              ev_modem_i,
  input  logic              ev_tx_ovf_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_en_i,
  input  logic [DW-1:0]     wdata_i,
  output logic [DW-1:0]     rdata_o,
  output logic              irq_o
);
  localparam logic [CNT_W-1:0] TRIG_INIT = CNT_W'(TRIG_RST);

  logic [CNT_W-1:0] rx_trig_q, tx_trig_q;
  logic [DW-1:0]    status, raw, mask, set_vec, clr_vec;
  logic             wr_ien, wr_idis;

  assign wr_ien  = wr_en_i && (addr_i == OFS_IEN);
  assign wr_idis = wr_en_i && (addr_i == OFS_IDIS);
  assign clr_vec = (wr_en_i && (addr_i == OFS_RAW)) ? wdata_i : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rx_trig_q <= TRIG_INIT;
      tx_trig_q <= TRIG_INIT;
    end else if (wr_en_i) begin
      if (addr_i == OFS_RXTRG) rx_trig_q <= wdata_i[CNT_W-1:0];
      if (addr_i == OFS_TXTRG) tx_trig_q <= wdata_i[CNT_W-1:0];
    end
  end

  uart_irq_status #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_status (
    .clk_i, .rst_ni, .rx_count_i, .tx_count_i,
    .rx_trig_i(rx_trig_q), .tx_trig_i(tx_trig_q), .status_o(status)
  );

  always_comb begin
    set_vec               = '0;
    set_vec[B_TX_FUL:0]   = status[B_TX_FUL:0];
    set_vec[B_TX_TRG_RAW] = status[B_TX_TRG_STAT];
    set_vec[B_RX_OVR]     = ev_rx_ovr_i;
    set_vec[B_FRAME]      = ev_frame_i;
    set_vec[B_PARITY]     = ev_parity_i;
    set_vec[B_RX_TMO]     = ev_rx_tmo_i;
    set_vec[B_MODEM]      = ev_modem_i;
    set_vec[B_TX_OVF]     = ev_tx_ovf_i;
  end

  uart_irq_raw u_raw (
    .clk_i, .rst_ni, .set_i(set_vec), .clr_i(clr_vec), .raw_o(raw)
  );

  uart_irq_mask u_mask (
    .clk_i, .rst_ni, .en_i(wr_ien), .dis_i(wr_idis), .wdata_i, .mask_o(mask)
  );

  always_comb begin
    case (addr_i)
      OFS_MASK:  rdata_o = mask;
      OFS_RAW:   rdata_o = raw;
      OFS_RXTRG: rdata_o = {{(DW-CNT_W){1'b0}}, rx_trig_q};
      OFS_TXTRG: rdata_o = {{(DW-CNT_W){1'b0}}, tx_trig_q};
      OFS_STAT:  rdata_o = status;
      default:   rdata_o = '0;
    endcase
  end

  assign irq_o = |(mask & raw);

  AST_IRQ_NEEDS_MASK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (mask != '0) && (raw != '0)); // R7
  AST_TRIG_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> $stable(rx_trig_q) && $stable(tx_trig_q)); // R10
endmodule

// File: tb/uart_irq_ctrl_tb_top.sv
module uart_irq_ctrl_tb_top;
  localparam int DEPTH = 64;
  localparam int CNT_W = 7;

  logic             clk = 0, rst_n = 0;
  logic [CNT_W-1:0] rx_cnt = 7'd10, tx_cnt = 7'd10;
  logic [5:0]       ev = '0; // ovr, frame, parity, tmo, modem, txovf
  logic [7:0]       addr = '0;
  logic             wr_en = 0;
  logic [31:0]      wdata = '0, rdata;
  logic             irq;
  int               total = 0, bad = 0;
  logic [31:0]      rv;

  always #4 clk = ~clk;

  uart_irq_ctrl dut_i (
    .clk_i(clk), .rst_ni(rst_n), .rx_count_i(rx_cnt), .tx_count_i(tx_cnt),
    .ev_rx_ovr_i(ev[0]), .ev_frame_i(ev[1]), .ev_parity_i(ev[2]),
    .ev_rx_tmo_i(ev[3]), .ev_modem_i(ev[4]), .ev_tx_ovf_i(ev[5]),
    .addr_i(addr), .wr_en_i(wr_en), .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq)
  );

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%08h exp=%08h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); addr = a; wdata = d; wr_en = 1;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk); addr = a; #1; d = rdata;
  endtask

  task automatic pulse(input int idx);
    @(negedge clk); ev[idx] = 1'b1;
    @(negedge clk); ev = '0;
  endtask

  function automatic logic [31:0] exp_stat(int rx, int tx, int rt, int tt);
    logic [31:0] s = '0;
    s[0]  = rx >= rt;  s[1] = rx == 0;  s[2] = rx == DEPTH;
    s[3]  = tx == 0;   s[4] = tx == DEPTH;
    s[13] = tx >= tt;
    return s;
  endfunction

  task automatic summary;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog got=%08h exp=%08h", 32'd0, 32'd1);
    summary();
  end

  initial begin
    int trigs[4] = '{0, 1, 32, 64};
    int evpos[6] = '{5, 6, 7, 8, 9, 12};
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R11 reset state
    rd(8'h10, rv); chk("R11 mask reset", rv, 0);
    rd(8'h14, rv); chk("R11 raw reset", rv, 0);
    rd(8'h20, rv); chk("R11 rx trig reset", rv, 32'h20);
    rd(8'h44, rv); chk("R11 tx trig reset", rv, 32'h20);
    chk("R7 irq reset", {31'd0, irq}, 0);
    wr(8'h20, 32'hFFFF_FF85); rd(8'h20, rv); chk("R11 trig width", rv, 32'h05);

    // R1 R2 status sweep
    foreach (trigs[t]) begin
      wr(8'h20, trigs[t]); wr(8'h44, trigs[3 - t]);
      for (int c = 0; c <= DEPTH; c++) begin
        @(negedge clk); rx_cnt = CNT_W'(c); tx_cnt = CNT_W'(DEPTH - c);
        rd(8'h2C, rv);
        chk("R1 R2 status", rv, exp_stat(c, DEPTH - c, trigs[t], trigs[3 - t]));
      end
    end
    wr(8'h20, 32); wr(8'h44, 32);
    @(negedge clk); rx_cnt = 10; tx_cnt = 10;

    // R3 sticky, R8 clear
    wr(8'h14, 32'hFFFF_FFFF); rd(8'h14, rv); chk("R8 clear all", rv, 0);
    @(negedge clk); rx_cnt = 0; @(negedge clk); rx_cnt = 10;
    repeat (3) @(negedge clk);
    rd(8'h14, rv); chk("R3 rx empty sticky", rv, 32'h2);
    @(negedge clk); rx_cnt = 64; @(negedge clk); rx_cnt = 10;
    rd(8'h14, rv); chk("R3 rx full trig sticky", rv, 32'h7);
    wr(8'h14, 32'hFFFF_FFFF);
    @(negedge clk); tx_cnt = 64; @(negedge clk); tx_cnt = 10;
    rd(8'h14, rv); chk("R2 tx full trig raw10", rv, 32'h410);
    wr(8'h14, 32'h0000_0400); rd(8'h14, rv); chk("R8 partial clear", rv, 32'h10);
    wr(8'h14, 32'hFFFF_FFFF);

    // R4 events
    foreach (evpos[i]) begin
      pulse(i); rd(8'h14, rv);
      chk("R4 event bit", rv, 32'd1 << evpos[i]);
      wr(8'h14, 32'hFFFF_FFFF);
    end

    // R5 R6 mask
    wr(8'h08, 32'h20); rd(8'h10, rv); chk("R5 enable", rv, 32'h20);
    wr(8'h08, 32'h80); rd(8'h10, rv); chk("R5 enable or", rv, 32'hA0);
    wr(8'h0C, 32'h20); rd(8'h10, rv); chk("R6 disable", rv, 32'h80);
    wr(8'h10, 32'hFFFF); rd(8'h10, rv); chk("R6 mask ro", rv, 32'h80);
    wr(8'h08, 32'hFFFF_FFFF); rd(8'h10, rv); chk("R5 impl bits", rv, 32'h17FF);
    wr(8'h0C, 32'hFFFF_FF7F); rd(8'h10, rv); chk("R6 disable many", rv, 32'h80);

    // R7 interrupt
    @(negedge clk); chk("R7 idle", {31'd0, irq}, 0);
    pulse(0); chk("R7 unmasked event", {31'd0, irq}, 0);
    pulse(2); chk("R7 masked event", {31'd0, irq}, 1);
    rd(8'h14, rv); chk("R8 two bits", rv, 32'hA0);
    wr(8'h14, 32'h20); rd(8'h14, rv); chk("R8 w1c one bit", rv, 32'h80);
    chk("R7 still high", {31'd0, irq}, 1);
    wr(8'h14, 32'h80); chk("R7 cleared", {31'd0, irq}, 0);
    wr(8'h0C, 32'h80);

    // R9 set wins
    @(negedge clk); addr = 8'h14; wdata = 32'h40; wr_en = 1; ev[1] = 1'b1;
    @(negedge clk); wr_en = 0; ev = '0;
    rd(8'h14, rv); chk("R9 set wins", rv, 32'h40);
    wr(8'h14, 32'hFFFF_FFFF);

    // R10 unmapped
    rd(8'h00, rv); chk("R10 read 00", rv, 0);
    rd(8'h04, rv); chk("R10 read 04", rv, 0);
    rd(8'h30, rv); chk("R10 read 30", rv, 0);
    wr(8'h08, 32'h10);
    wr(8'h04, 32'hFFFF_FFFF); wr(8'h18, 32'hFFFF_FFFF); wr(8'h2C, 32'hFFFF_FFFF);
    wr(8'h24, 32'hFFFF_FFFF);
    rd(8'h10, rv); chk("R10 mask kept", rv, 32'h10);
    rd(8'h14, rv); chk("R10 raw kept", rv, 0);
    rd(8'h20, rv); chk("R10 rx trig kept", rv, 32'h20);
    rd(8'h44, rv); chk("R10 tx trig kept", rv, 32'h20);
    rd(8'h2C, rv); chk("R10 status unaffected", rv, exp_stat(10, 10, 32, 32));
    summary();
  end
endmodule